// File: doc/BRIEF.md
# Fragmented Mailbox Message Receiver

This engine drains one message from a slot-based peer mailbox into a local byte buffer. The peer delivers a message as one or more fragments. Each fragment is a header slot followed by payload slots. The engine reads the header, checks the fragment length against the space still free in the buffer, and copies the payload. It writes whole slots first and then a trailing partial slot, of which it keeps only the low bytes. Byte writes go out through a write port that carries a byte address, the slot word and a byte count. The storage itself lives outside the block.

A request starts with a one-cycle `start` pulse and a buffer capacity in bytes. The engine clears any pending interrupt status and waits for the peer to report ready. It then reads fragments until it meets one marked complete, a zero-length one, or a full buffer. When a fragment ends incomplete and the mailbox is empty, the engine rings the peer's doorbell so the peer sends more. A failed attempt is restarted from the start of the buffer, up to a fixed number of attempts. A broken fragment, or running out of attempts, ends with a link reset. The result is a one-cycle `done` pulse with a status code and the number of bytes stored. Every wait polls its condition at a fixed cycle interval and gives up after a fixed number of polls.

Top module: `msg_reasm_rx`

## Requirements
- R1: A `start` with `capacity` equal to zero completes with status 4 (input error) and a byte count of 0. It pulses neither `intr_clr` nor `slot_pop`.
- R2: A `start` with nonzero capacity pulses `intr_clr` exactly once, before any slot is read. The capacity is sampled at `start`.
- R3: Bit 31 of a header slot marks the fragment complete, and bits 24:16 give its payload length in bytes. All other header bits are ignored.
- R4: A fragment whose length is larger than the free buffer space (capacity minus bytes stored) ends the request with status 2 (length mismatch), a link reset and a byte count of 0.
- R5: A fragment of length L is stored as floor(L/4) whole slots and then, if L mod 4 is nonzero, one more slot of which only the low L mod 4 bytes are written. Byte k of a slot is bits 8k+7:8k and goes to the next consecutive byte address. No write reaches at or beyond the capacity.
- R6: If `peer_ready` is low after the whole slots of a fragment are read, the request ends with status 3 (peer not ready) and a link reset.
- R7: When a fragment not marked complete has been read and `peer_fill` is zero, `doorbell` pulses once.
- R8: Fragments are read until one is complete, one has zero length, or the free space reaches zero. The attempt succeeds only if the last fragment is complete with nonzero length. It then ends with status 0, no link reset, and the total bytes stored as the byte count.
- R9: A zero-length fragment pulses `zero_len_warn`. Any attempt that ends without success restarts at buffer address 0.
- R10: At most MAX_TRIES attempts are made. An attempt also fails when `peer_ready` stays low through a whole wait. After the last failed attempt, the request ends with a link reset and status 3.
- R11: A wait for a header or payload slot that expires ends the request with status 1 (timeout) and a link reset.
- R12: A wait samples its condition on its first cycle and then every POLL_CYC cycles. It expires after WAIT_POLLS samples have all found the condition false.
- R13: `done` is a one-cycle pulse. `start` is ignored while a request is in progress. `slot_pop` is raised only while `peer_fill` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request strobe |
| capacity | input | CAP_W | Buffer capacity in bytes for this request |
| peer_fill | input | FILL_W | Number of filled slots waiting in the mailbox |
| peer_ready | input | 1 | Peer ready flag |
| slot_data | input | SLOT_W | Slot at the head of the mailbox |
| slot_pop | output | 1 | Consumes the head slot at this clock edge |
| intr_clr | output | 1 | Clears pending interrupt status |
| doorbell | output | 1 | Asks the peer for more data |
| link_rst | output | 1 | Link reset request |
| buf_we | output | 1 | Buffer write strobe |
| buf_addr | output | CAP_W | Byte address of the first written byte |
| buf_wdata | output | SLOT_W | Slot word to write, low byte first |
| buf_nbytes | output | NB_W | Number of low bytes of buf_wdata to write |
| zero_len_warn | output | 1 | Pulses when a zero-length fragment is read |
| done | output | 1 | Request finished (one cycle) |
| status | output | 3 | 0 ok, 1 timeout, 2 length mismatch, 3 peer not ready, 4 input error |
| byte_count | output | CAP_W | Bytes stored, valid with done |

## Verification
The bound checker watches four things on every cycle. It checks that slots are popped only from a non-empty mailbox, and that every buffer write stays inside the sampled capacity with a byte count between 1 and 4. It checks that `done` lasts one cycle and that a result other than success never reports stored bytes. The rest can only be shown by the bench's scenarios: the reassembled byte contents, the masking of tail bytes, the retry restart after a zero-length or buffer-filling fragment, the doorbell handshake with a peer that refills late, the distinct error codes, and the poll and timeout timing.

// File: rtl/rx_pkg.sv
package rx_pkg;

   typedef enum logic [2:0] {
      RX_OK        = 3'd0,
      RX_TIMEOUT   = 3'd1,
      RX_LEN_ERR   = 3'd2,
      RX_NOT_READY = 3'd3,
      RX_BAD_INPUT = 3'd4
   } rx_status_e;

   typedef enum logic [3:0] {
      S_IDLE, S_CLR, S_RDY, S_HDRW, S_HDRR, S_CHK, S_PAYW, S_PAYR,
      S_RCHK, S_TAILW, S_TAILR, S_FEND, S_FAIL, S_RST, S_RSTW, S_DONE
   } rx_state_e;

endpackage

// File: rtl/rx_poll_wait.sv
// Polled wait: samples a condition once every POLL_CYC cycles while running,
// flags a hit or, after WAIT_POLLS false samples, an expiry.
module rx_poll_wait #(
   parameter int POLL_CYC   = 8,
   parameter int WAIT_POLLS = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic run,
   input  logic cond,
   output logic hit,
   output logic expire
);
   localparam int TW = $clog2(WAIT_POLLS + 1);

   logic          sample;
   logic [TW-1:0] tcnt_q;

   generate
      if (POLL_CYC > 1) begin : g_div
         localparam int PC_W = $clog2(POLL_CYC);
         logic [PC_W-1:0] pcnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      pcnt_q <= '0;
            else if (arm)    pcnt_q <= '0;
            else if (run)    pcnt_q <= (pcnt_q == '0) ? PC_W'(POLL_CYC - 1) : pcnt_q - 1'b1;
         end
         assign sample = (pcnt_q == '0);
      end else begin : g_nodiv
         assign sample = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               tcnt_q <= '0;
      else if (arm)             tcnt_q <= '0;
      else if (run && sample)   tcnt_q <= tcnt_q + 1'b1;
   end

   assign hit    = run && sample && cond;
   assign expire = run && sample && !cond && (tcnt_q == TW'(WAIT_POLLS - 1));
endmodule

// File: rtl/rx_frag_plan.sv
// Splits a fragment length into whole slots and tail bytes and checks it
// against the free space of the buffer.
module rx_frag_plan #(
   parameter int LEN_W = 9,
   parameter int CAP_W = 12,
   parameter int SHIFT = 2
) (
   input  logic [LEN_W-1:0] frag_len,
   input  logic [CAP_W-1:0] space_left,
   output logic [LEN_W-1:0] words,
   output logic [SHIFT-1:0] tail,
   output logic             too_big
);
   localparam int CMP_W = ((LEN_W > CAP_W) ? LEN_W : CAP_W) + 1;

   assign words   = frag_len >> SHIFT;
   assign tail    = frag_len[SHIFT-1:0];
   assign too_big = CMP_W'(frag_len) > CMP_W'(space_left);
endmodule

// File: rtl/msg_reasm_rx.sv
module msg_reasm_rx
   import rx_pkg::*;
#(
   parameter int SLOT_W     = 32,
   parameter int LEN_LSB    = 16,
   parameter int LEN_W      = 9,
   parameter int CMPL_BIT   = 31,
   parameter int FILL_W     = 8,
   parameter int CAP_W      = 12,
   parameter int MAX_TRIES  = 5,
   parameter int POLL_CYC   = 8,
   parameter int WAIT_POLLS = 64,
   localparam int BYTES     = SLOT_W / 8,
   localparam int NB_W      = $clog2(BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CAP_W-1:0]  capacity,
   input  logic [FILL_W-1:0] peer_fill,
   input  logic              peer_ready,
   input  logic [SLOT_W-1:0] slot_data,
   output logic              slot_pop,
   output logic              intr_clr,
   output logic              doorbell,
   output logic              link_rst,
   output logic              buf_we,
   output logic [CAP_W-1:0]  buf_addr,
   output logic [SLOT_W-1:0] buf_wdata,
   output logic [NB_W-1:0]   buf_nbytes,
   output logic              zero_len_warn,
   output logic              done,
   output logic [2:0]        status,
   output logic [CAP_W-1:0]  byte_count
);
   localparam int SHIFT = $clog2(BYTES);
   localparam int TRY_W = $clog2(MAX_TRIES + 1);

   generate
      if (SLOT_W < 16 || (SLOT_W & (SLOT_W - 1)) != 0) begin : g_bad_slot
         $error("SLOT_W must be a power of two of at least 16");
      end
      if (LEN_LSB + LEN_W > SLOT_W || CMPL_BIT >= SLOT_W ||
          (CMPL_BIT >= LEN_LSB && CMPL_BIT < LEN_LSB + LEN_W)) begin : g_bad_hdr
         $error("header fields do not fit the slot or overlap");
      end
      if (MAX_TRIES < 1 || POLL_CYC < 1 || WAIT_POLLS < 1) begin : g_bad_cnt
         $error("MAX_TRIES, POLL_CYC and WAIT_POLLS must be at least 1");
      end
   endgenerate

   rx_state_e        state_q, state_d;
   rx_status_e       stat_q, err_code;
   logic             set_err;
   logic [CAP_W-1:0] cap_q, off_q, cnt_q, left;
   logic [TRY_W-1:0] try_q;
   logic [LEN_W-1:0] len_q, words_q, f_words;
   logic [SHIFT-1:0] rem_q, f_rem;
   logic             cmpl_q, f_big;
   logic             w_run, w_cond, w_hit, w_exp, last_try, frag_ok, frag_more;

   assign left      = cap_q - off_q;
   assign last_try  = (try_q == TRY_W'(MAX_TRIES - 1));
   assign frag_ok   = cmpl_q && (len_q != '0);
   assign frag_more = !cmpl_q && (len_q != '0) && (left != '0);

   rx_frag_plan #(.LEN_W(LEN_W), .CAP_W(CAP_W), .SHIFT(SHIFT)) u_plan (
      .frag_len   (len_q),
      .space_left (left),
      .words      (f_words),
      .tail       (f_rem),
      .too_big    (f_big)
   );

   assign w_run  = state_q inside {S_RDY, S_HDRW, S_PAYW, S_TAILW, S_RSTW};
   assign w_cond = (state_q == S_RDY || state_q == S_RSTW) ? peer_ready : (peer_fill != '0);

   rx_poll_wait #(.POLL_CYC(POLL_CYC), .WAIT_POLLS(WAIT_POLLS)) u_wait (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (state_d != state_q),
      .run    (w_run),
      .cond   (w_cond),
      .hit    (w_hit),
      .expire (w_exp)
   );

   always_comb begin
      state_d  = state_q;
      set_err  = 1'b0;
      err_code = RX_OK;
      unique case (state_q)
         S_IDLE:  if (start) state_d = (capacity == '0) ? S_DONE : S_CLR;
         S_CLR:   state_d = S_RDY;
         S_RDY: begin
            if (w_hit)      state_d = S_HDRW;
            else if (w_exp) state_d = S_FAIL;
         end
         S_HDRW: begin
            if (w_hit)      state_d = S_HDRR;
            else if (w_exp) begin state_d = S_RST; set_err = 1'b1; err_code = RX_TIMEOUT; end
         end
         S_HDRR:  state_d = S_CHK;
         S_CHK: begin
            if (f_big)              begin state_d = S_RST; set_err = 1'b1; err_code = RX_LEN_ERR; end
            else if (f_words != '0) state_d = S_PAYW;
            else                    state_d = S_RCHK;
         end
         S_PAYW: begin
            if (w_hit)      state_d = S_PAYR;
            else if (w_exp) begin state_d = S_RST; set_err = 1'b1; err_code = RX_TIMEOUT; end
         end
         S_PAYR:  state_d = (words_q == LEN_W'(1)) ? S_RCHK : S_PAYW;
         S_RCHK: begin
            if (!peer_ready)        begin state_d = S_RST; set_err = 1'b1; err_code = RX_NOT_READY; end
            else if (rem_q != '0)   state_d = S_TAILW;
            else                    state_d = S_FEND;
         end
         S_TAILW: begin
            if (w_hit)      state_d = S_TAILR;
            else if (w_exp) begin state_d = S_RST; set_err = 1'b1; err_code = RX_TIMEOUT; end
         end
         S_TAILR: state_d = S_FEND;
         S_FEND: begin
            if (frag_more)    state_d = S_HDRW;
            else if (frag_ok) state_d = S_DONE;
            else              state_d = S_FAIL;
         end
         S_FAIL: begin
            if (last_try) begin state_d = S_RST; set_err = 1'b1; err_code = RX_NOT_READY; end
            else          state_d = S_RDY;
         end
         S_RST:   state_d = S_RSTW;
         S_RSTW:  if (w_hit || w_exp) state_d = S_DONE;
         S_DONE:  state_d = S_IDLE;
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         stat_q  <= RX_OK;
         cap_q   <= '0;
         off_q   <= '0;
         cnt_q   <= '0;
         try_q   <= '0;
         len_q   <= '0;
         words_q <= '0;
         rem_q   <= '0;
         cmpl_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (set_err) stat_q <= err_code;
         unique case (state_q)
            S_IDLE: if (start) begin
               cap_q <= capacity;
               off_q <= '0;
               try_q <= '0;
               cnt_q <= '0;
               if (capacity == '0) stat_q <= RX_BAD_INPUT;
            end
            S_HDRR: begin
               len_q  <= slot_data[LEN_LSB +: LEN_W];
               cmpl_q <= slot_data[CMPL_BIT];
            end
            S_CHK: begin
               words_q <= f_words;
               rem_q   <= f_rem;
            end
            S_PAYR: begin
               off_q   <= off_q + CAP_W'(BYTES);
               words_q <= words_q - LEN_W'(1);
            end
            S_TAILR: off_q <= off_q + CAP_W'(rem_q);
            S_FEND: if (!frag_more && frag_ok) begin
               stat_q <= RX_OK;
               cnt_q  <= off_q;
            end
            S_FAIL: if (!last_try) begin
               try_q <= try_q + 1'b1;
               off_q <= '0;
            end
            default: ;
         endcase
      end
   end

   assign slot_pop      = (state_q == S_HDRR) || (state_q == S_PAYR) || (state_q == S_TAILR);
   assign buf_we        = (state_q == S_PAYR) || (state_q == S_TAILR);
   assign buf_addr      = off_q;
   assign buf_wdata     = slot_data;
   assign buf_nbytes    = (state_q == S_TAILR) ? NB_W'(rem_q) : NB_W'(BYTES);
   assign intr_clr      = (state_q == S_CLR);
   assign link_rst      = (state_q == S_RST);
   assign doorbell      = (state_q == S_FEND) && !cmpl_q && (peer_fill == '0);
   assign zero_len_warn = (state_q == S_CHK) && (len_q == '0);
   assign done          = (state_q == S_DONE);
   assign status        = stat_q;
   assign byte_count    = cnt_q;
endmodule

// File: rtl/msg_reasm_rx_chk.sv
module msg_reasm_rx_chk #(
   parameter int SLOT_W = 32,
   parameter int CAP_W  = 12,
   parameter int FILL_W = 8,
   localparam int BYTES = SLOT_W / 8,
   localparam int NB_W  = $clog2(BYTES + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [FILL_W-1:0] peer_fill,
   input logic              slot_pop,
   input logic              buf_we,
   input logic [CAP_W-1:0]  buf_addr,
   input logic [NB_W-1:0]   buf_nbytes,
   input logic [CAP_W-1:0]  cap_lim,
   input logic              done,
   input logic [2:0]        status,
   input logic [CAP_W-1:0]  byte_count
);
   // R13
   pop_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_pop |-> (peer_fill != '0));

   // R13
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> ((CAP_W+1)'(buf_addr) + (CAP_W+1)'(buf_nbytes) <= (CAP_W+1)'(cap_lim)));

   // R5
   nbytes_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> (buf_nbytes != '0 && buf_nbytes <= NB_W'(BYTES)));

   // R8
   fail_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status != 3'd0) |-> (byte_count == '0));
endmodule

bind msg_reasm_rx msg_reasm_rx_chk #(
   .SLOT_W (SLOT_W),
   .CAP_W  (CAP_W),
   .FILL_W (FILL_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .peer_fill  (peer_fill),
   .slot_pop   (slot_pop),
   .buf_we     (buf_we),
   .buf_addr   (buf_addr),
   .buf_nbytes (buf_nbytes),
   .cap_lim    (cap_q),
   .done       (done),
   .status     (status),
   .byte_count (byte_count)
);

// File: tb/msg_reasm_rx_tb.sv
module msg_reasm_rx_tb;
   localparam int CAP_W = 10;
   localparam int PC    = 4;
   localparam int WP    = 20;
   localparam int TRIES = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic             start = 1'b0;
   logic [CAP_W-1:0] capacity = '0;
   logic [7:0]       peer_fill;
   logic             peer_ready;
   logic [31:0]      slot_data;
   logic             slot_pop, intr_clr, doorbell, link_rst, buf_we, zero_len_warn, done;
   logic [CAP_W-1:0] buf_addr, byte_count;
   logic [31:0]      buf_wdata;
   logic [2:0]       buf_nbytes, status;

   msg_reasm_rx #(.CAP_W(CAP_W), .POLL_CYC(PC), .WAIT_POLLS(WP), .MAX_TRIES(TRIES)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .capacity(capacity),
      .peer_fill(peer_fill), .peer_ready(peer_ready), .slot_data(slot_data),
      .slot_pop(slot_pop), .intr_clr(intr_clr), .doorbell(doorbell), .link_rst(link_rst),
      .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_nbytes(buf_nbytes),
      .zero_len_warn(zero_len_warn), .done(done), .status(status), .byte_count(byte_count)
   );

   // mailbox and buffer models
   logic [31:0] mq [0:1023];
   logic [7:0]  bmem [0:1023];
   logic [7:0]  msg [0:1023];
   int tl = 0;
   int n_pop = 0, n_intr = 0, n_link = 0, n_bell = 0, n_warn = 0, n_done = 0;
   bit ready_base = 1'b1, drop_en = 1'b0;
   int drop_at = 0, drop_base = 0;

   assign peer_fill  = ((tl - n_pop) > 255) ? 8'd255 : 8'(tl - n_pop);
   assign slot_data  = mq[n_pop % 1024];
   assign peer_ready = ready_base && !(drop_en && ((n_pop - drop_base) >= drop_at));

   always @(posedge clk) begin
      if (slot_pop)      n_pop  <= n_pop + 1;
      if (intr_clr)      n_intr <= n_intr + 1;
      if (link_rst)      n_link <= n_link + 1;
      if (doorbell)      n_bell <= n_bell + 1;
      if (zero_len_warn) n_warn <= n_warn + 1;
      if (done)          n_done <= n_done + 1;
      if (buf_we)
         for (int k = 0; k < 4; k++)
            if (k < int'(buf_nbytes)) bmem[(int'(buf_addr) + k) % 1024] <= buf_wdata[8*k +: 8];
   end

   int checks = 0, fails = 0;
   bit finished = 1'b0;
   int b_pop, b_intr, b_link, b_bell, b_warn, b_done;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic snap();
      b_pop = n_pop; b_intr = n_intr; b_link = n_link;
      b_bell = n_bell; b_warn = n_warn; b_done = n_done;
   endtask

   task automatic push(input logic [31:0] w);
      mq[tl % 1024] = w;
      tl++;
   endtask

   function automatic logic [31:0] mk_hdr(input int n, input bit c);
      logic [31:0] h;
      h = $urandom;
      h[31] = c;
      h[24:16] = 9'(n);
      return h;
   endfunction

   task automatic push_frag(input int off, input int n, input bit c);
      logic [31:0] w;
      push(mk_hdr(n, c));
      for (int i = 0; i < n; i += 4) begin
         w = $urandom;
         for (int b = 0; b < 4; b++)
            if (i + b < n) w[8*b +: 8] = msg[off + i + b];
         push(w);
      end
   endtask

   task automatic push_msg(input int total, input int frag);
      int off, n;
      off = 0;
      while (off < total) begin
         n = (total - off < frag) ? total - off : frag;
         push_frag(off, n, (off + n) == total);
         off += n;
      end
   endtask

   task automatic fresh();
      @(negedge clk);
      tl = n_pop;
      for (int k = 0; k < 1024; k++) begin
         bmem[k] = 8'hEE;
         msg[k]  = 8'($urandom);
      end
   endtask

   function automatic int byte_mismatch(input int from, input int n, input int src);
      int bad;
      bad = 0;
      for (int k = 0; k < n; k++)
         if (bmem[from + k] !== msg[src + k]) bad++;
      return bad;
   endfunction

   task automatic go(input int cap, output int cyc);
      @(negedge clk);
      capacity = CAP_W'(cap);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 1;
      while (!done && cyc < 20000) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   initial begin
      int cyc, len, frag, cap;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R13 reset state
      chk(done == 1'b0 && slot_pop == 1'b0 && buf_we == 1'b0 && link_rst == 1'b0 && intr_clr == 1'b0,
          "R13 outputs idle in reset", {done, slot_pop, buf_we, link_rst, intr_clr}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 zero capacity
      fresh(); push_msg(8, 8); snap();
      go(0, cyc);
      chk(status == 3'd4, "R1 status on zero capacity", status, 4);
      chk(n_pop == b_pop && n_intr == b_intr && byte_count == 0, "R1 no pop, no clear, count 0",
          (n_pop - b_pop) + (n_intr - b_intr), 0);

      // R5 tail bytes, exact fit
      fresh(); push_msg(6, 6); snap();
      go(6, cyc);
      chk(status == 3'd0 && byte_count == 6, "R5 tail fragment result", byte_count, 6);
      chk(byte_mismatch(0, 6, 0) == 0, "R5 tail bytes stored", byte_mismatch(0, 6, 0), 0);
      chk(bmem[6] == 8'hEE, "R5 masked tail bytes untouched", bmem[6], 8'hEE);
      chk(n_intr - b_intr == 1, "R2 interrupt status cleared once", n_intr - b_intr, 1);

      // R3 R8 random multi-fragment messages, all queued up front
      for (int r = 0; r < 6; r++) begin
         len  = 1 + int'($urandom % 300);
         frag = 1 + int'($urandom % 40);
         cap  = len + int'($urandom % 50);
         fresh(); push_msg(len, frag); snap();
         go(cap, cyc);
         chk(status == 3'd0, "R8 random message status", status, 0);
         chk(byte_count == CAP_W'(len), "R8 random message count", byte_count, len);
         chk(byte_mismatch(0, len, 0) == 0, "R3 R5 random payload bytes", byte_mismatch(0, len, 0), 0);
         chk(bmem[len] == 8'hEE, "R5 nothing past message", bmem[len], 8'hEE);
         chk(n_link == b_link && n_bell == b_bell, "R7 R8 no reset, no doorbell on clean run",
             (n_link - b_link) + (n_bell - b_bell), 0);
         chk(tl == n_pop, "R8 mailbox drained", tl - n_pop, 0);
      end

      // R4 length mismatch
      fresh(); push_msg(6, 6); snap();
      go(5, cyc);
      chk(status == 3'd2 && byte_count == 0, "R4 length mismatch status", status, 2);
      chk(n_link - b_link == 1, "R4 link reset", n_link - b_link, 1);

      // R11 R12 header timeout and its timing
      fresh(); snap();
      go(16, cyc);
      chk(status == 3'd1, "R11 header timeout status", status, 1);
      chk(n_link - b_link == 1, "R11 link reset on timeout", n_link - b_link, 1);
      chk(cyc >= (WP - 1) * PC && cyc <= (WP - 1) * PC + 12, "R12 timeout length", cyc, (WP - 1) * PC);

      // R11 payload timeout
      fresh(); push(mk_hdr(8, 1'b1)); push(32'h01020304); snap();
      go(16, cyc);
      chk(status == 3'd1 && n_pop - b_pop == 2, "R11 payload timeout", status, 1);

      // R6 peer drops ready after the whole slots
      fresh(); push_msg(8, 8); snap();
      drop_base = n_pop; drop_at = 3; drop_en = 1'b1;
      go(16, cyc);
      drop_en = 1'b0;
      chk(status == 3'd3 && n_link - b_link == 1, "R6 not ready after payload", status, 3);

      // R10 peer never ready
      fresh(); push_msg(4, 4); snap();
      ready_base = 1'b0;
      go(16, cyc);
      ready_base = 1'b1;
      chk(status == 3'd3 && n_link - b_link == 1, "R10 retries exhausted", status, 3);
      chk(n_pop == b_pop, "R10 nothing read while not ready", n_pop - b_pop, 0);
      chk(cyc >= TRIES * (WP - 1) * PC, "R10 all attempts waited", cyc, TRIES * (WP - 1) * PC);

      // R9 zero-length fragment then a good message on the retry
      fresh(); push(mk_hdr(0, 1'b1)); push_msg(10, 10); snap();
      go(32, cyc);
      chk(n_warn - b_warn == 1, "R9 zero length warning", n_warn - b_warn, 1);
      chk(status == 3'd0 && byte_count == 10, "R9 retry succeeds", byte_count, 10);
      chk(byte_mismatch(0, 10, 0) == 0, "R9 retry restarts at address 0", byte_mismatch(0, 10, 0), 0);

      // R8 buffer filled by an incomplete fragment, retry reads a new one
      fresh(); push_frag(0, 8, 1'b0); push_frag(100, 4, 1'b1); snap();
      go(8, cyc);
      chk(status == 3'd0 && byte_count == 4, "R8 full buffer ends attempt", byte_count, 4);
      chk(byte_mismatch(0, 4, 100) == 0, "R8 second attempt bytes", byte_mismatch(0, 4, 100), 0);

      // R7 doorbell when the mailbox runs dry mid-message
      fresh(); push_frag(0, 4, 1'b0); snap();
      @(negedge clk); capacity = CAP_W'(20); start = 1'b1;
      @(negedge clk); start = 1'b0;
      cyc = 0;
      while (n_bell == b_bell && cyc < 2000) begin @(negedge clk); cyc++; end
      chk(n_bell - b_bell == 1, "R7 doorbell rung", n_bell - b_bell, 1);
      push_frag(4, 8, 1'b1);
      while (!done && cyc < 4000) begin @(negedge clk); cyc++; end
      chk(status == 3'd0 && byte_count == 12, "R7 message completes after refill", byte_count, 12);
      chk(byte_mismatch(0, 12, 0) == 0 && n_bell - b_bell == 1, "R7 bytes and single doorbell",
          byte_mismatch(0, 12, 0), 0);

      // R13 start ignored while busy
      fresh(); snap();
      @(negedge clk); capacity = CAP_W'(16); start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (20) @(negedge clk);
      capacity = '0; start = 1'b1;
      @(negedge clk); start = 1'b0;
      cyc = 0;
      while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
      chk(status == 3'd1, "R13 busy start ignored", status, 1);
      repeat (5) @(negedge clk);
      chk(n_done - b_done == 1, "R13 one done pulse", n_done - b_done, 1);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule